// File: doc/BRIEF.md
# Cyclic Priority Enforcer

This block picks one matching word out of a wide active-low match vector: a 0 in bit i means word i matched. Instead of always favouring word 0, it searches from a start point that moves, so that repeated searches share the grants fairly among the words that keep matching. The output is a one-hot-low grant vector, the binary index of the granted word, and a flag raised when no word matched.

Internally two fixed-priority first-zero finders run side by side. One scans the raw vector upward from index 0. The other scans the same vector after it has been ORed with a stored history mask, which covers every index below the start point. A grant from the masked finder wins. When the masked finder finds nothing, the result of the raw finder is used, and this gives the wrap-around. Two policies decide how the history mask moves. In resume mode the next search starts just after the word last granted. In step mode the start point moves up one word each clock cycle, whatever was granted.

A search is made on every clock cycle. The results appear on registered outputs one cycle after the vector is sampled.

Top module: `cyclic_prio_enforcer`

## Requirements
- R1: When at least one bit of `req_n_i` is 0, one cycle later `grant_n_o` has exactly one 0 bit, that bit was 0 in the sampled `req_n_i`, and `none_o` is 0.
- R2: When every bit of the sampled `req_n_i` is 1, one cycle later `none_o` is 1, `grant_n_o` is all ones and `grant_idx_o` is 0.
- R3: While `rst` is high at a clock edge, the outputs become `none_o`=1, `grant_n_o` all ones and `grant_idx_o`=0. The first search after reset starts at index 0.
- R4: With `step_mode_i`=0, after word k is granted the next search takes the lowest index at or above k+1 whose bit is 0, and wraps to the lowest 0 from index 0 upward when there is none. After word N-1 is granted the next search starts at index 0.
- R5: With `step_mode_i`=0, a cycle with no match leaves the start point unchanged.
- R6: With `step_mode_i`=1, the start point moves up by one index on every cycle, whether or not a grant is made, and goes from N-1 back to 0.
- R7: Whenever `none_o` is 0, `grant_idx_o` is the binary position of the 0 bit in `grant_n_o`.
- R8: The start point carries over when `step_mode_i` changes. The policy applied in a cycle is the one selected by `step_mode_i` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_mode_i | input | 1 | 0 = resume after last grant, 1 = advance start every cycle |
| req_n_i | input | NWORDS | Active-low match vector, bit i is word i |
| grant_n_o | output | NWORDS | One-hot-low grant, registered |
| grant_idx_o | output | $clog2(NWORDS) | Index of the granted word, registered |
| none_o | output | 1 | No word matched, registered |

## Verification
The wrap-around fallback and the update of the history mask land in the same cycle in two ways. One is a grant of word N-1 in resume mode, where the masked finder is empty and the mask must reload to index 0. The other is a change of policy in the same cycle as a grant. The bench provokes both with directed vectors: a single 0 at the top index, and an all-zero vector that shows the start point directly, given on the cycles around a mode toggle. Each result is judged against a reference that scans cyclically from a start index tracked in the bench.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  typedef enum logic {
    MODE_RESUME = 1'b0,
    MODE_STEP   = 1'b1
  } cpe_mode_e;
endpackage

// File: rtl/cpe_zero_finder.sv
// Fixed-priority search for the lowest-index 0 in an active-low vector.
module cpe_zero_finder #(
  parameter int NWORDS = 256,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic [NWORDS-1:0] vec_n_i,
  output logic [NWORDS-1:0] hit_n_o,
  output logic [IW-1:0]     hit_idx_o,
  output logic              found_o
);
  always_comb begin
    hit_n_o   = '1;
    hit_idx_o = '0;
    found_o   = 1'b0;
    for (int i = 0; i < NWORDS; i++) begin
      if (!found_o && !vec_n_i[i]) begin
        hit_n_o[i] = 1'b0;
        hit_idx_o  = IW'(i);
        found_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpe_history.sv
// History mask: bit i set means index i lies below the current start point.
module cpe_history
  import cpe_pkg::*;
#(
  parameter int NWORDS = 256,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  cpe_mode_e         mode_i,
  input  logic              grant_valid_i,
  input  logic [IW-1:0]     grant_idx_i,
  output logic [NWORDS-1:0] mask_o
);
  localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

  logic [NWORDS-1:0] prefix;
  logic [NWORDS-1:0] mask_nxt;

  // prefix of the granted word: every index up to and including it
  for (genvar g = 0; g < NWORDS; g++) begin : g_prefix
    assign prefix[g] = (IW'(g) <= grant_idx_i);
  end

  always_comb begin
    mask_nxt = mask_o;
    if (mode_i == MODE_STEP) begin
      if (mask_o[NWORDS-2]) mask_nxt = '0;
      else                  mask_nxt = {mask_o[NWORDS-2:0], 1'b1};
    end else if (grant_valid_i) begin
      if (grant_idx_i == LAST) mask_nxt = '0;
      else                     mask_nxt = prefix;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else     mask_o <= mask_nxt;
  end

  // R4: the top word is never masked, so the mask always names a reachable start
  assert_top_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
    !mask_o[NWORDS-1]);

  // R4: the mask is always a contiguous run from index 0
  assert_prefix_shape_R4: assert property (@(posedge clk) disable iff (rst)
    ((mask_o + 1'b1) & mask_o) == '0);

  // R5: a resume-mode cycle with no match keeps the history
  assert_hold_on_miss_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RESUME && !grant_valid_i) |=> $stable(mask_o));

  // R6: in step mode the run of masked words grows by one or wraps to empty
  assert_step_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_STEP) |=>
      ($countones(mask_o) == $countones($past(mask_o)) + 1) ||
      ($past(mask_o[NWORDS-2]) && mask_o == '0));
endmodule

// File: rtl/cyclic_prio_enforcer.sv
module cyclic_prio_enforcer
  import cpe_pkg::*;
#(
  parameter int NWORDS = 256,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_mode_i,
  input  logic [NWORDS-1:0] req_n_i,
  output logic [NWORDS-1:0] grant_n_o,
  output logic [IW-1:0]     grant_idx_o,
  output logic              none_o
);
  logic [NWORDS-1:0] hist_mask;
  logic [NWORDS-1:0] masked_req_n;
  logic [NWORDS-1:0] raw_hit_n, late_hit_n, sel_hit_n;
  logic [IW-1:0]     raw_idx, late_idx, sel_idx;
  logic              raw_found, late_found;
  cpe_mode_e         mode;

  assign mode         = cpe_mode_e'(step_mode_i);
  assign masked_req_n = req_n_i | hist_mask;

  cpe_zero_finder #(.NWORDS(NWORDS)) u_raw_finder (
    .vec_n_i   (req_n_i),
    .hit_n_o   (raw_hit_n),
    .hit_idx_o (raw_idx),
    .found_o   (raw_found)
  );

  cpe_zero_finder #(.NWORDS(NWORDS)) u_late_finder (
    .vec_n_i   (masked_req_n),
    .hit_n_o   (late_hit_n),
    .hit_idx_o (late_idx),
    .found_o   (late_found)
  );

  // a hit above the start point wins, otherwise wrap to the raw search
  assign sel_hit_n = late_found ? late_hit_n : raw_hit_n;
  assign sel_idx   = late_found ? late_idx   : raw_idx;

  cpe_history #(.NWORDS(NWORDS)) u_history (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode),
    .grant_valid_i (raw_found),
    .grant_idx_i   (sel_idx),
    .mask_o        (hist_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_n_o   <= '1;
      grant_idx_o <= '0;
      none_o      <= 1'b1;
    end else begin
      grant_n_o   <= sel_hit_n;
      grant_idx_o <= sel_idx;
      none_o      <= !raw_found;
    end
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    !none_o |-> $countones(~grant_n_o) == 1);

  assert_grant_requested_R1: assert property (@(posedge clk) disable iff (rst)
    !none_o |-> ((~grant_n_o) & $past(req_n_i)) == '0);

  assert_none_idle_R2: assert property (@(posedge clk) disable iff (rst)
    none_o |-> (&grant_n_o && grant_idx_o == '0));

  assert_idx_matches_R7: assert property (@(posedge clk) disable iff (rst)
    !none_o |-> !grant_n_o[grant_idx_o]);
endmodule

// File: tb/cyclic_prio_enforcer_test.sv
`timescale 1ns/1ps
module cyclic_prio_enforcer_test;
  localparam int N  = 256;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_mode = 1'b0;
  logic [N-1:0]  req_n = '1;
  logic [N-1:0]  grant_n;
  logic [IW-1:0] grant_idx;
  logic          none;

  int n_checks = 0;
  int n_fails  = 0;
  int start_pt = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  cyclic_prio_enforcer #(.NWORDS(N)) uut (
    .clk         (clk),
    .rst         (rst),
    .step_mode_i (step_mode),
    .req_n_i     (req_n),
    .grant_n_o   (grant_n),
    .grant_idx_o (grant_idx),
    .none_o      (none)
  );

  // reference: first 0 met while scanning cyclically from s; -1 when none
  function automatic int ref_pick(input logic [N-1:0] v, input int s);
    for (int j = 0; j < N; j++) begin
      int p;
      p = (s + j) % N;
      if (!v[p]) return p;
    end
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // called at a negedge: drive, let one posedge pass, compare at the next negedge
  task automatic apply(input logic [N-1:0] v, input bit stepm, input string tag);
    int exp_idx;
    logic [N-1:0] exp_g;
    req_n     = v;
    step_mode = stepm;
    exp_idx   = ref_pick(v, start_pt);
    @(negedge clk);
    if (exp_idx < 0) begin
      check(none == 1'b1, "R2", "none flag", none, 1);
      check(&grant_n, "R2", "grant all ones", $countones(grant_n), N);
      check(grant_idx == '0, "R2", "idle index", grant_idx, 0);
    end else begin
      exp_g = '1;
      exp_g[exp_idx] = 1'b0;
      check(none == 1'b0, "R1", "none flag", none, 0);
      check(grant_n == exp_g, tag, "granted word", grant_idx, exp_idx);
      check(int'(grant_idx) == exp_idx, "R7", "grant index", grant_idx, exp_idx);
    end
    if (stepm)             start_pt = (start_pt + 1) % N;
    else if (exp_idx >= 0) start_pt = (exp_idx + 1) % N;
  endtask

  function automatic logic [N-1:0] sparse_vec(input int zeros);
    logic [N-1:0] v;
    v = '1;
    for (int k = 0; k < zeros; k++) v[$urandom % N] = 1'b0;
    return v;
  endfunction

  function automatic logic [N-1:0] one_zero(input int pos);
    logic [N-1:0] v;
    v = '1;
    v[pos] = 1'b0;
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    // R3: reset state on the outputs
    check(none == 1'b1, "R3", "reset none", none, 1);
    check(&grant_n, "R3", "reset grant", $countones(grant_n), N);
    check(grant_idx == '0, "R3", "reset index", grant_idx, 0);
    rst = 1'b0;
    start_pt = 0;
    // R3: first search after reset starts at index 0
    apply('0, 1'b0, "R3");

    // R4: resume just after the last grant
    apply(one_zero(7) & one_zero(200), 1'b0, "R4");
    apply(one_zero(7) & one_zero(200), 1'b0, "R4");
    apply(one_zero(7) & one_zero(200), 1'b0, "R4");
    // R4: grant of the top word, next search from index 0
    apply(one_zero(N-1), 1'b0, "R4");
    apply('0, 1'b0, "R4");
    // R5: a miss keeps the start point
    apply(one_zero(40), 1'b0, "R4");
    apply('1, 1'b0, "R5");
    apply('1, 1'b0, "R5");
    apply('0, 1'b0, "R5");

    // R6: step mode advances each cycle regardless of grants
    apply('1, 1'b1, "R6");
    apply(one_zero(3), 1'b1, "R6");
    apply('0, 1'b1, "R6");
    // R6: run the start point across the top and wrap to 0
    for (int c = 0; c < N + 4; c++) apply((c % 3 == 0) ? '0 : sparse_vec(4), 1'b1, "R6");

    // R8: a grant, then a policy change in the same cycle as another grant
    apply(one_zero(10), 1'b0, "R8");
    apply('0, 1'b1, "R8");
    apply('0, 1'b0, "R8");
    apply('0, 1'b1, "R8");
    apply(one_zero(N-1), 1'b0, "R8");
    apply('0, 1'b1, "R8");

    // random mix in both modes
    for (int c = 0; c < 1500; c++) begin
      logic [N-1:0] v;
      int r;
      r = $urandom % 10;
      if (r == 0)      v = '1;
      else if (r == 1) v = one_zero($urandom % N);
      else             v = sparse_vec(1 + $urandom % 12);
      apply(v, ((c / 200) % 2) == 1, ((c / 200) % 2) == 1 ? "R6" : "R4");
    end

    // R3: reset again mid-run clears the history
    rst = 1'b1;
    @(negedge clk);
    check(none == 1'b1, "R3", "second reset none", none, 1);
    rst = 1'b0;
    start_pt = 0;
    apply('0, 1'b0, "R3");
    finish_run();
  end
endmodule